// File: doc/BRIEF.md
# Thermal Sensor Calibration Converter

This block translates between a temperature in whole degrees Celsius and the 8-bit code a thermal sensor reports, in either direction. It holds two trim codes, one taken at a first calibration temperature and one at a second. These are captured from a trim word on a load pulse and checked as they are captured. A first code that is zero or outside a configured window is replaced from a default trim word. A second code is replaced only when it is zero.

A configuration input selects one of three mappings. Two-point mode interpolates linearly between the calibration points. One-point mode shifts by the difference between the first trim code and the first calibration temperature. Every other encoding adds or removes a fixed configured offset. Two-point conversions use a sequential signed restoring divider, so they take many cycles. The other mappings finish in one cycle.

Requests enter through a valid/ready handshake. The requester raises `req_valid` and holds its direction and value. A transfer happens on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that transfer until the result comes out, so at most one conversion is in flight. A request raised while the block is busy is not taken, and it has no effect if the requester drops it before `req_ready` returns. The result side has no back-pressure. `res_valid` is a single-cycle pulse, and the result value and flags stay on the outputs until the next result.

Top module: `calib_conv`

## Requirements
- R1: On a clock edge with `trim_load` high, the first trim code E1 is taken from `trim_word[7:0]` and the second code E2 from `trim_word[15:8]`. With `trim_load` low, both codes keep their values, whatever `trim_word` does.
- R2: At load, E1 is replaced by `cfg_dflt_trim[7:0]` when the raw value is zero, below `cfg_trim_min`, or above `cfg_trim_max`. The limits themselves are accepted.
- R3: At load, E2 is replaced by `cfg_dflt_trim[15:8]` only when its raw value is zero. It has no range check.
- R4: With `cfg_mode` = 2'b01 (two-point), the forward conversion (`req_dir` = 0) gives (T−T1)·(E2−E1)/(T2−T1)+E1. The reverse conversion (`req_dir` = 1) gives (C−E1)·(T2−T1)/(E2−E1)+T1. The division truncates toward zero.
- R5: With `cfg_mode` = 2'b10 (one-point), forward gives T+E1−T1 and reverse gives C−E1+T1.
- R6: With `cfg_mode` = 2'b00 or 2'b11 (fixed offset), forward gives T+`cfg_offset` and reverse gives C−`cfg_offset`.
- R7: When RANGE_CHECK is 1, a reverse conversion of a code below 75 or above 175 gives `res_nodata` = 1, `res_ok` = 0 and value 0, in any mode. The codes 75 and 175 are converted normally.
- R8: In two-point mode, if E1 equals E2 or T1 equals T2, the result has `res_bad_cal` = 1, `res_ok` = 0 and value 0, and no division is started.
- R9: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the edge that raises `res_valid`.
- R10: `res_valid` rises 1 edge after acceptance for every result that needs no division. It rises 2·W+2 edges after acceptance (34 by default) for a two-point division. It is high for exactly one cycle.
- R11: After reset, `req_ready` = 1, `res_valid` = 0, the result value and flags are 0, and both trim codes are 0. A two-point request then reports `res_bad_cal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Mapping select: 01 two-point, 10 one-point, 00/11 fixed offset |
| cfg_t1 | input | TW | First calibration temperature, signed °C |
| cfg_t2 | input | TW | Second calibration temperature, signed °C |
| cfg_offset | input | TW | Signed offset for fixed-offset mode |
| cfg_trim_min | input | TW | Lowest accepted first trim code |
| cfg_trim_max | input | TW | Highest accepted first trim code |
| cfg_dflt_trim | input | 2*TW | Default trim codes, E1 in the low byte, E2 in the high byte |
| trim_load | input | 1 | Capture and check `trim_word` on this edge |
| trim_word | input | 2*TW | Raw trim codes, E1 in bits 7:0, E2 in bits 15:8 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_dir | input | 1 | 0: temperature to code, 1: code to temperature |
| req_value | input | W | Signed temperature or code to convert |
| res_valid | output | 1 | One-cycle result strobe |
| res_value | output | W | Signed converted value, 0 when not ok |
| res_ok | output | 1 | Value is a valid conversion |
| res_nodata | output | 1 | Code outside the accepted sensor range |
| res_bad_cal | output | 1 | Two-point calibration is degenerate |

## Verification
Each mapping is driven in both directions. Two-point inputs are placed on both sides of the first calibration point, so negative numerators appear. One of them, −2016/60, separates truncation toward zero (−33) from flooring (−34). Range-check codes sit at 74, 75, 175 and 176 to pin down the window edges, and the offset mode is also tried through its second encoding. Trim words with a zero, a below-window, an above-window and an exactly-at-limit first code separate the substitution rules for E1 from those for E2. Equal trim codes and equal calibration temperatures are used to check the degenerate case. A request offered during a division shows that nothing is accepted while busy. A trim word that changes with no load pulse shows that the captured codes hold.

// File: rtl/calib_pkg.sv
package calib_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED   = 2'b00,
    MODE_TWO_PT  = 2'b01,
    MODE_ONE_PT  = 2'b10,
    MODE_FIXED_B = 2'b11
  } cal_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_DIV  = 2'd2
  } conv_state_e;
endpackage

// File: rtl/calib_trim_reg.sv
module calib_trim_reg #(
  parameter int TW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [2*TW-1:0] trim_word,
  input  logic [TW-1:0]   lim_lo,
  input  logic [TW-1:0]   lim_hi,
  input  logic [2*TW-1:0] dflt_word,
  output logic [TW-1:0]   e1,
  output logic [TW-1:0]   e2
);
  logic [TW-1:0] raw1, raw2, e1_nxt, e2_nxt;

  always_comb begin
    raw1   = trim_word[TW-1:0];
    raw2   = trim_word[2*TW-1:TW];
    e1_nxt = (raw1 == '0 || raw1 < lim_lo || raw1 > lim_hi) ? dflt_word[TW-1:0] : raw1;
    e2_nxt = (raw2 == '0) ? dflt_word[2*TW-1:TW] : raw2;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1 <= '0;
      e2 <= '0;
    end else if (load) begin
      e1 <= e1_nxt;
      e2 <= e2_nxt;
    end
  end

  // R1
  trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(e1) && $stable(e2)));

  // R2
  trim_e1_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && dflt_word[TW-1:0] != '0) |=> (e1 != '0));
endmodule

// File: rtl/calib_divider.sv
module calib_divider #(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [DW-1:0] num,
  input  logic signed [DW-1:0] den,
  output logic                 done,
  output logic signed [DW-1:0] quot
);
  localparam int CW = $clog2(DW + 1);

  logic [DW:0]   rem;
  logic [DW-1:0] qreg, dmag, nmag_in, dmag_in;
  logic          neg, busy;
  logic [CW-1:0] cnt;
  logic [DW:0]   shifted;
  logic [DW+1:0] trial;

  always_comb begin
    nmag_in = num[DW-1] ? (~num + 1'b1) : num;
    dmag_in = den[DW-1] ? (~den + 1'b1) : den;
    shifted = {rem[DW-1:0], qreg[DW-1]};
    trial   = {1'b0, shifted} - {2'b00, dmag};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem  <= '0;
      qreg <= '0;
      dmag <= '0;
      neg  <= 1'b0;
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        qreg <= nmag_in;
        dmag <= dmag_in;
        neg  <= num[DW-1] ^ den[DW-1];
        cnt  <= CW'(DW);
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= trial[DW+1] ? shifted : trial[DW:0];
        qreg <= {qreg[DW-2:0], ~trial[DW+1]};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = neg ? -$signed(qreg) : $signed(qreg);

  // R4
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem < {1'b0, dmag}));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/calib_conv.sv
module calib_conv
  import calib_pkg::*;
#(
  parameter int W           = 16,
  parameter int TW          = 8,
  parameter bit RANGE_CHECK = 1'b1,
  parameter int CODE_LO     = 75,
  parameter int CODE_HI     = 175
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_mode,
  input  logic signed [TW-1:0] cfg_t1,
  input  logic signed [TW-1:0] cfg_t2,
  input  logic signed [TW-1:0] cfg_offset,
  input  logic [TW-1:0]        cfg_trim_min,
  input  logic [TW-1:0]        cfg_trim_max,
  input  logic [2*TW-1:0]      cfg_dflt_trim,
  input  logic                 trim_load,
  input  logic [2*TW-1:0]      trim_word,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_dir,
  input  logic signed [W-1:0]  req_value,
  output logic                 res_valid,
  output logic signed [W-1:0]  res_value,
  output logic                 res_ok,
  output logic                 res_nodata,
  output logic                 res_bad_cal
);
  localparam int DW = 2 * W;
  localparam logic signed [W-1:0] LO_V = W'(CODE_LO);
  localparam logic signed [W-1:0] HI_V = W'(CODE_HI);

  conv_state_e         state;
  cal_mode_e           op_mode;
  logic                op_dir;
  logic signed [W-1:0] op_val;

  logic [TW-1:0]        e1, e2;
  logic signed [W-1:0]  e1s, e2s, t1s, t2s, offs;
  logic signed [W-1:0]  diff_a, diff_b, div_den, base, direct_val;
  logic signed [DW-1:0] num_x, den_x, quot;
  logic                 nodata, degenerate, div_start, div_done;

  calib_trim_reg #(.TW(TW)) u_trim (
    .clk(clk), .rst_n(rst_n), .load(trim_load), .trim_word(trim_word),
    .lim_lo(cfg_trim_min), .lim_hi(cfg_trim_max), .dflt_word(cfg_dflt_trim),
    .e1(e1), .e2(e2)
  );

  always_comb begin
    e1s  = {{(W-TW){1'b0}}, e1};
    e2s  = {{(W-TW){1'b0}}, e2};
    t1s  = {{(W-TW){cfg_t1[TW-1]}}, cfg_t1};
    t2s  = {{(W-TW){cfg_t2[TW-1]}}, cfg_t2};
    offs = {{(W-TW){cfg_offset[TW-1]}}, cfg_offset};
    if (!op_dir) begin
      diff_a  = op_val - t1s;
      diff_b  = e2s - e1s;
      div_den = t2s - t1s;
      base    = e1s;
    end else begin
      diff_a  = op_val - e1s;
      diff_b  = t2s - t1s;
      div_den = e2s - e1s;
      base    = t1s;
    end
    num_x = {{(DW-W){diff_a[W-1]}}, diff_a} * {{(DW-W){diff_b[W-1]}}, diff_b};
    den_x = {{(DW-W){div_den[W-1]}}, div_den};
    degenerate = (e1 == e2) || (cfg_t1 == cfg_t2);
    if (op_mode == MODE_ONE_PT)
      direct_val = op_dir ? (op_val - e1s + t1s) : (op_val + e1s - t1s);
    else
      direct_val = op_dir ? (op_val - offs) : (op_val + offs);
  end

  generate
    if (RANGE_CHECK) begin : g_range
      assign nodata = op_dir && (op_val < LO_V || op_val > HI_V);
    end else begin : g_no_range
      assign nodata = 1'b0;
    end
  endgenerate

  assign div_start = (state == ST_PREP) && (op_mode == MODE_TWO_PT) && !nodata && !degenerate;
  assign req_ready = (state == ST_IDLE);

  calib_divider #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(num_x), .den(den_x),
    .done(div_done), .quot(quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      op_mode     <= MODE_FIXED;
      op_dir      <= 1'b0;
      op_val      <= '0;
      res_valid   <= 1'b0;
      res_value   <= '0;
      res_ok      <= 1'b0;
      res_nodata  <= 1'b0;
      res_bad_cal <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          op_mode <= cal_mode_e'(cfg_mode);
          op_dir  <= req_dir;
          op_val  <= req_value;
          state   <= ST_PREP;
        end
        ST_PREP: begin
          if (nodata || (op_mode == MODE_TWO_PT && degenerate)) begin
            res_valid   <= 1'b1;
            res_value   <= '0;
            res_ok      <= 1'b0;
            res_nodata  <= nodata;
            res_bad_cal <= !nodata;
            state       <= ST_IDLE;
          end else if (op_mode == MODE_TWO_PT) begin
            state <= ST_DIV;
          end else begin
            res_valid   <= 1'b1;
            res_value   <= direct_val;
            res_ok      <= 1'b1;
            res_nodata  <= 1'b0;
            res_bad_cal <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        ST_DIV: if (div_done) begin
          res_valid   <= 1'b1;
          res_value   <= $signed(quot[W-1:0]) + base;
          res_ok      <= 1'b1;
          res_nodata  <= 1'b0;
          res_bad_cal <= 1'b0;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R9
  ready_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> req_ready);

  // R7
  nodata_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_nodata) |-> (!res_ok && res_value == '0 && !res_bad_cal));

  // R8
  bad_cal_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_bad_cal) |-> (!res_ok && res_value == '0));
endmodule

// File: tb/tb_calib_conv.sv
module tb_calib_conv;
  localparam int W = 16;
  localparam int DIV_LAT = 2 * W + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic signed [7:0] cfg_t1 = 8'sd25, cfg_t2 = 8'sd85, cfg_offset = 8'sd50;
  logic [7:0] cfg_trim_min = 8'd40, cfg_trim_max = 8'd120;
  logic [15:0] cfg_dflt_trim = 16'h7030;
  logic trim_load = 1'b0;
  logic [15:0] trim_word = 16'h0000;
  logic req_valid = 1'b0, req_dir = 1'b0;
  logic signed [W-1:0] req_value = '0;
  logic req_ready, res_valid, res_ok, res_nodata, res_bad_cal;
  logic signed [W-1:0] res_value;

  calib_conv dut (.*);

  always #5 clk = ~clk;

  typedef struct { int val; int ok; int nd; int bad; string tag; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  int me1 = 0, me2 = 0, cnt = 0;
  bit pending = 0, fire = 0;
  string cur_tag = "R11";

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pending = 0; fire = 0; cnt = 0; me1 = 0; me2 = 0;
    end else begin
      fire = 0;
      if (trim_load) begin
        me1 = trim_word[7:0];
        if (me1 == 0 || me1 < cfg_trim_min || me1 > cfg_trim_max) me1 = cfg_dflt_trim[7:0];
        me2 = trim_word[15:8];
        if (me2 == 0) me2 = cfg_dflt_trim[15:8];
      end
      if (pending) begin
        cnt--;
        if (cnt == 0) begin fire = 1; pending = 0; end
      end else if (req_valid) begin
        exp_t e;
        int v, t1, t2, off;
        v = req_value; t1 = cfg_t1; t2 = cfg_t2; off = cfg_offset;
        e.tag = cur_tag; e.ok = 1; e.nd = 0; e.bad = 0; cnt = 1;
        if (req_dir && (v < 75 || v > 175)) begin
          e.val = 0; e.ok = 0; e.nd = 1;
        end else if (cfg_mode == 2'b01) begin
          if (me1 == me2 || t1 == t2) begin
            e.val = 0; e.ok = 0; e.bad = 1;
          end else begin
            cnt = DIV_LAT;
            if (!req_dir) e.val = (v - t1) * (me2 - me1) / (t2 - t1) + me1;
            else          e.val = (v - me1) * (t2 - t1) / (me2 - me1) + t1;
          end
        end else if (cfg_mode == 2'b10) begin
          e.val = req_dir ? v - me1 + t1 : v + me1 - t1;
        end else begin
          e.val = req_dir ? v - off : v + off;
        end
        exp_q.push_back(e);
        pending = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 ready", int'(req_ready), int'(!pending));
      chk("R10 valid", int'(res_valid), int'(fire));
      if (fire && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " value"}, int'(res_value), e.val);
        chk({e.tag, " ok"}, int'(res_ok), e.ok);
        chk({e.tag, " nodata"}, int'(res_nodata), e.nd);
        chk({e.tag, " bad_cal"}, int'(res_bad_cal), e.bad);
      end
    end
  end

  task automatic conv(input string tag, input logic [1:0] m, input bit d, input int v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_tag = tag; cfg_mode = m; req_dir = d; req_value = W'(v); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (pending) @(negedge clk);
  endtask

  task automatic load_trim(input logic [15:0] w);
    @(negedge clk);
    trim_word = w; trim_load = 1'b1;
    @(negedge clk);
    trim_load = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 ready", int'(req_ready), 1);
    chk("R11 valid", int'(res_valid), 0);
    chk("R11 value", int'(res_value), 0);
    chk("R11 flags", int'({res_ok, res_nodata, res_bad_cal}), 0);
    conv("R11", 2'b01, 1'b0, 40);

    load_trim(16'h7A32);
    conv("R1", 2'b10, 1'b0, 25);
    conv("R5", 2'b10, 1'b1, 100);
    conv("R4", 2'b01, 1'b0, 60);
    conv("R4", 2'b01, 1'b0, 10);
    conv("R4", 2'b01, 1'b0, -3);
    conv("R4", 2'b01, 1'b1, 100);
    conv("R4", 2'b01, 1'b1, 76);
    conv("R7", 2'b01, 1'b1, 74);
    conv("R7", 2'b10, 1'b1, 176);
    conv("R7", 2'b00, 1'b1, 75);
    conv("R7", 2'b00, 1'b1, 175);
    conv("R6", 2'b00, 1'b0, 30);
    conv("R6", 2'b11, 1'b0, -20);

    // R9 request offered mid-division must not be taken
    fork
      conv("R9", 2'b01, 1'b0, 60);
      begin
        repeat (6) @(negedge clk);
        req_value = 16'sd5; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
      end
    join

    // R1 trim word changes with no load
    @(negedge clk);
    trim_word = 16'h2266;
    conv("R1", 2'b10, 1'b0, 25);

    cfg_t2 = 8'sd25;
    conv("R8", 2'b01, 1'b0, 30);
    cfg_t2 = 8'sd85;
    load_trim(16'h4040);
    conv("R8", 2'b01, 1'b1, 100);

    load_trim(16'h0000);
    conv("R2", 2'b10, 1'b0, 25);
    conv("R3", 2'b01, 1'b1, 112);
    load_trim(16'h0A05);
    conv("R2", 2'b10, 1'b0, 25);
    conv("R3", 2'b01, 1'b1, 130);
    load_trim(16'hFF7B);
    conv("R2", 2'b10, 1'b0, 25);
    load_trim(16'h0028);
    conv("R2", 2'b10, 1'b0, 25);
    conv("R3", 2'b01, 1'b0, 85);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule